// File: doc/BRIEF.md
# Note Table Sequencer

The sequencer walks through an external read-only table of tone half-period values and presents the entry at the current address as the tone to play. Each entry is held for a set number of clock cycles. The address then moves up by one, and after the last entry it returns to zero, so playback loops without end. The table read data passes straight to the tone output with no processing, and the current address is an output so that its upper bits can drive status lights.

A two-bit tempo code selects one of four note durations. The four durations are parameters in clock cycles. At a 33 MHz clock the defaults give 1/25 s for the normal tempo and 1/75, 1/50 and 1/15 s for the others. A pause input freezes the address and the duration timer and raises a separate mute output, which is meant to gate the tone generator's enable while the tone value stays stable. The block has no reset port: its registers take power-up initial values of zero.

Top module: `note_sequencer`

## Requirements
- R1: At power-up the address is 0 and the timer is 0, so the first note is held for a full duration before the first advance.
- R2: When pause is low, each note is held for exactly the selected duration in clock cycles. The address then increments by one and the timer restarts.
- R3: `tone` equals `tbl_data` in the same cycle, and `tbl_addr` always shows the current note address.
- R4: After the last address, 2^ADDR_W-1, the next advance goes to address 0.
- R5: Tempo codes map to durations as follows: 2'b00 gives DUR_NORMAL, 2'b01 gives DUR_FAST, 2'b10 gives DUR_BRISK and 2'b11 gives DUR_SLOW.
- R6: While pause is high, the address and the timer hold their values, `mute` is 1 and `tone` does not change. While pause is low, `mute` is 0.
- R7: After pause is released, the same note plays for only the cycles it had left when pause was raised.
- R8: If the tempo changes mid-note to a duration that the elapsed cycles already meet, the note ends at the next clock edge. The timer never exceeds the largest duration minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pause | input | 1 | Freeze playback and mute |
| tempo | input | 2 | Note duration select |
| tbl_addr | output | ADDR_W | Current table address |
| tbl_data | input | DATA_W | Table read data at tbl_addr |
| tone | output | DATA_W | Half-period value for the tone generator |
| mute | output | 1 | High while paused |

## Verification
The hardest case to reach is a tempo switch to a shorter duration after the current note has already passed that shorter length. Without care, this is where a timer with an equality compare would run far past its limit. The bench gets there by selecting the longest tempo, waiting for a note boundary, and letting four cycles pass. It then selects a two-cycle tempo and expects the address to advance on the very next edge. The pause test also raises pause one cycle into a note, so that the remaining-time count after release is observable.

// File: rtl/note_sequencer.sv
module note_sequencer #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 24,
  parameter int DUR_NORMAL = 1320000,
  parameter int DUR_FAST   = 440000,
  parameter int DUR_BRISK  = 660000,
  parameter int DUR_SLOW   = 2200000
) (
  input  logic              clk,
  input  logic              pause,
  input  logic [1:0]        tempo,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic [DATA_W-1:0] tone,
  output logic              mute
);
  localparam int DMAX_A = (DUR_NORMAL > DUR_FAST) ? DUR_NORMAL : DUR_FAST;
  localparam int DMAX_B = (DUR_BRISK > DUR_SLOW) ? DUR_BRISK : DUR_SLOW;
  localparam int DMAX   = (DMAX_A > DMAX_B) ? DMAX_A : DMAX_B;
  localparam int TW     = $clog2(DMAX + 1);

  logic [ADDR_W-1:0] addr_q  = '0;
  logic [TW-1:0]     timer_q = '0;
  logic [TW-1:0]     dur;
  logic              note_done;

  always_comb begin
    case (tempo)
      2'b00:   dur = TW'(DUR_NORMAL);
      2'b01:   dur = TW'(DUR_FAST);
      2'b10:   dur = TW'(DUR_BRISK);
      default: dur = TW'(DUR_SLOW);
    endcase
  end

  assign note_done = ({1'b0, timer_q} + (TW+1)'(1)) >= {1'b0, dur};

  always_ff @(posedge clk) begin
    if (!pause) begin
      if (note_done) begin
        addr_q  <= addr_q + ADDR_W'(1);
        timer_q <= '0;
      end else begin
        timer_q <= timer_q + TW'(1);
      end
    end
  end

  assign tbl_addr = addr_q;
  assign tone     = tbl_data;
  assign mute     = pause;
endmodule

// File: rtl/note_sequencer_chk.sv
module note_sequencer_chk #(
  parameter int ADDR_W = 10,
  parameter int TW     = 22,
  parameter int DMAX   = 2200000
) (
  input logic              clk,
  input logic              pause,
  input logic [ADDR_W-1:0] addr,
  input logic [TW-1:0]     timer
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_PAUSE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!started)
    pause |=> $stable(addr)); // R6
  AST_PAUSE_HOLDS_TIMER: assert property (@(posedge clk) disable iff (!started)
    pause |=> $stable(timer)); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!started)
    (addr != $past(addr)) |-> (addr == $past(addr) + ADDR_W'(1))); // R4
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!started)
    (addr != $past(addr)) |-> (timer == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!started)
    timer < TW'(DMAX)); // R8
endmodule

bind note_sequencer note_sequencer_chk #(.ADDR_W(ADDR_W), .TW(TW), .DMAX(DMAX)) u_chk (
  .clk(clk), .pause(pause), .addr(tbl_addr), .timer(timer_q)
);

// File: tb/note_sequencer_tb.sv
`timescale 1ns/1ps
module note_sequencer_tb;
  localparam int AW = 3;
  localparam int DW = 24;
  localparam int D0 = 4, D1 = 2, D2 = 3, D3 = 6;

  logic          clk = 1'b0;
  logic          pause = 1'b0;
  logic [1:0]    tempo = 2'b00;
  logic [AW-1:0] tbl_addr;
  logic [DW-1:0] tbl_data, tone;
  logic          mute;
  int            n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign tbl_data = DW'(tbl_addr) * 24'd1000 + 24'd7;

  note_sequencer #(.ADDR_W(AW), .DATA_W(DW), .DUR_NORMAL(D0), .DUR_FAST(D1),
                   .DUR_BRISK(D2), .DUR_SLOW(D3)) u_dut (
    .clk(clk), .pause(pause), .tempo(tempo), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .tone(tone), .mute(mute));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_change(output int n);
    logic [AW-1:0] a0 = tbl_addr;
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (tbl_addr == a0 && n < 100);
  endtask

  task automatic t_reset;
    #5;
    check("R1 addr at power-up", tbl_addr, 0);
    check("R6 mute low at power-up", mute, 0);
    check("R3 tone pass-through", tone, 7);
  endtask

  task automatic t_sequence;
    int n;
    for (int i = 1; i <= 10; i++) begin
      wait_change(n);
      check(i == 1 ? "R1 first note duration" : "R2 note duration", n, D0);
      check(i == 8 ? "R4 wrap to zero" : "R2 address step", tbl_addr, i % 8);
      check("R3 tone follows table", tone, (i % 8) * 1000 + 7);
    end
  endtask

  task automatic t_tempo;
    int n;
    int exp_d[4] = '{D0, D1, D2, D3};
    for (int c = 0; c < 4; c++) begin
      tempo = 2'(c);
      wait_change(n);
      wait_change(n);
      check("R5 tempo duration", n, exp_d[c]);
    end
    tempo = 2'b00;
    wait_change(n);
  endtask

  task automatic t_pause;
    int n; int bad = 0;
    logic [AW-1:0] a; logic [DW-1:0] t;
    wait_change(n);
    @(posedge clk); @(negedge clk);
    pause = 1'b1; a = tbl_addr; t = tone;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (tbl_addr != a || tone != t || mute != 1'b1) bad++;
    end
    check("R6 frozen while paused", bad, 0);
    pause = 1'b0; #1;
    check("R6 mute released", mute, 0);
    wait_change(n);
    check("R7 remaining cycles after resume", n, D0 - 1);
    check("R7 same note resumed", tbl_addr, 32'(a + AW'(1)));
  endtask

  task automatic t_shorten;
    int n;
    tempo = 2'b11;
    wait_change(n);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    tempo = 2'b01;
    wait_change(n);
    check("R8 shortened tempo ends note next edge", n, 1);
    wait_change(n);
    check("R8 following note at new tempo", n, D1);
    tempo = 2'b00;
  endtask

  initial begin
    fork
      begin
        t_reset; t_sequence; t_tempo; t_pause; t_shorten;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule